// File: doc/BRIEF.md
# Undersampled IQ Detector

This block converts a stream of signed ADC samples, taken from an intermediate-frequency RF signal, into baseband in-phase (I) and quadrature (Q) pairs. The ADC clock is picked so that each new sample advances the IF phase by an odd number of quarter periods. Any four consecutive samples therefore hold I, Q and their negatives in a fixed order. The block counts the sample phase and undoes the sign pattern. It routes each sample to the I or the Q path and emits one registered I/Q pair with a valid strobe for each complete group of four samples.

Two undersampling regimes are supported. The forward regime sees the quadrature component with positive sign on the second sample. The reverse regime sees it with negative sign there and with positive sign on the fourth sample. A static select input picks the regime. A sync input, asserted with the first sample of each RF pulse, forces that sample to be taken as the start of a group. This makes the I/Q assignment deterministic from pulse to pulse.

Top module: `iq_undersample_det`

## Requirements
- R1: While `rst_n` is low, `iq_valid` is low and `i_out` and `q_out` are zero. After reset, no strobe appears until four samples have been accepted.
- R2: With `regime_sel` = 0 at the group's first sample, the expected group order is +I, +Q, -I, -Q. The block outputs I = floor((a0 - a2)/2) and Q = floor((a1 - a3)/2), where aK is the K-th accepted sample of the group.
- R3: With `regime_sel` = 1 at the group's first sample, the expected group order is +I, -Q, -I, +Q. The block outputs I = floor((a0 - a2)/2) and Q = floor((a3 - a1)/2).
- R4: Any sample that must be negated and holds the most negative 14-bit code (-8192) is replaced by +8191 before averaging, instead of wrapping.
- R5: `iq_valid` is high for exactly one cycle, at the first rising edge after the edge that accepts the fourth sample of a group. `i_out` and `q_out` change only together with that strobe and hold their values otherwise.
- R6: Only cycles with `smp_valid` high advance the group position. Idle cycles between samples of a group do not change the result.
- R7: A sample accepted with `sync` high is the first sample of a new group. Any partly collected group is discarded and produces no strobe, even when the sync sample would have been its fourth.
- R8: The regime is captured at each group's first accepted sample. A change of `regime_sel` in the middle of a group takes effect from the next group.
- R9: Outputs are 16-bit two's complement values, sign-extended from the 14-bit average.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | High when `smp_data` carries a sample |
| smp_data | input | 14 | Signed ADC sample |
| sync | input | 1 | With `smp_valid`, marks the first sample of a group |
| regime_sel | input | 1 | 0 = forward order (+I,+Q,-I,-Q), 1 = reverse order (+I,-Q,-I,+Q) |
| iq_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| i_out | output | 16 | Signed in-phase average |
| q_out | output | 16 | Signed quadrature average |

## Verification
Two events can fall in the same cycle: a sync pulse and the sample that would otherwise complete a group. The bench provokes this by sending three samples and then raising sync on the fourth. It expects no strobe for the abandoned group and a correct pair for the group that the sync sample starts. A second collision is the strobe of one group falling in the same cycle as the first sample of the next group, which happens when groups are sent back to back. The scoreboard then checks that each strobe carries its own group's values, arrives exactly one cycle after its fourth sample, and is never followed by a second strobe in the next cycle.

// File: rtl/iqd_pkg.sv
// Shared types and constants for the undersampled IQ detector.
package iqd_pkg;

    // Number of samples per IQ group and width of the group position counter.
    localparam int unsigned GRP_LEN = 4;
    localparam int unsigned PH_W    = $clog2(GRP_LEN);

    // Sampling regime: sign/order sequence of the quadrature samples.
    typedef enum logic {
        REG_FWD = 1'b0,   // +I, +Q, -I, -Q
        REG_REV = 1'b1    // +I, -Q, -I, +Q
    } regime_e;

endpackage

// File: rtl/iqd_phase_ctrl.sv
// Group position tracker.
// Counts accepted samples modulo the group length, restarts on sync, and
// captures the sampling regime at the first sample of each group.
// Assumes sync is only meaningful together with smp_valid.
module iqd_phase_ctrl
    import iqd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic            sync,
    input  logic            regime_sel,
    output logic [PH_W-1:0] ph_cur,     // position of the sample now presented
    output logic [PH_W-1:0] phase_q,    // stored position of the next sample
    output regime_e         regime_q,   // regime in force for this group
    output logic            grp_last    // presented sample completes a group
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_LEN - 1);

    // Position of the current sample: sync forces the start of a group.
    always_comb begin
        ph_cur   = sync ? '0 : phase_q;
        grp_last = smp_valid && (ph_cur == PH_LAST);
    end

    // Advance the position on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (smp_valid) begin
            phase_q <= ph_cur + 1'b1;
        end
    end

    // Capture the regime on reset and at each group's first sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regime_q <= regime_e'(regime_sel);
        end else if (smp_valid && (ph_cur == '0)) begin
            regime_q <= regime_e'(regime_sel);
        end
    end

endmodule

// File: rtl/iqd_sign_fix.sv
// Sign corrector.
// Negates the sample when its group position and the regime call for it.
// The most negative code saturates to the most positive one.
// Assumes the regime only matters at positions 1 and 3.
module iqd_sign_fix
    import iqd_pkg::*;
#(
    parameter int unsigned DW = 14
) (
    input  logic signed [DW-1:0] smp_in,
    input  logic [PH_W-1:0]      ph_cur,
    input  regime_e              regime,
    output logic signed [DW-1:0] smp_fix
);

    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic                 do_neg;
    logic signed [DW-1:0] neg_val;

    // Decide whether this position carries a negated component.
    always_comb begin
        unique case (ph_cur)
            2'd0:    do_neg = 1'b0;
            2'd1:    do_neg = (regime == REG_REV);
            2'd2:    do_neg = 1'b1;
            default: do_neg = (regime == REG_FWD);
        endcase
    end

    // Saturating two's-complement negation and selection.
    always_comb begin
        neg_val = (smp_in == MOST_NEG) ? MOST_POS : -smp_in;
        smp_fix = do_neg ? neg_val : smp_in;
    end

endmodule

// File: rtl/iqd_combine.sv
// Group collector and averager.
// Stores the sign-corrected samples of a group by position. One cycle after
// the last sample it registers I and Q as halved sums, sign-extended.
// Assumes OW > DW.
module iqd_combine
    import iqd_pkg::*;
#(
    parameter int unsigned DW = 14,
    parameter int unsigned OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [PH_W-1:0]      ph_cur,
    input  logic signed [DW-1:0] smp_fix,
    input  logic                 grp_last,
    output logic                 iq_valid,
    output logic signed [OW-1:0] i_out,
    output logic signed [OW-1:0] q_out
);

    localparam int unsigned EXT = OW - DW;

    logic signed [DW-1:0] slot_q [GRP_LEN];
    logic                 done_q;
    logic signed [DW:0]   sum_i;
    logic signed [DW:0]   sum_q;
    logic signed [DW-1:0] avg_i;
    logic signed [DW-1:0] avg_q;

    // Hold each corrected sample in the slot for its position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < GRP_LEN; k++) slot_q[k] <= '0;
        end else if (smp_valid) begin
            for (int k = 0; k < GRP_LEN; k++) begin
                if (ph_cur == PH_W'(k)) slot_q[k] <= smp_fix;
            end
        end
    end

    // Remember that the group just completed.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= grp_last;
    end

    // Halved sums of the in-phase pair and the quadrature pair.
    always_comb begin
        sum_i = {slot_q[0][DW-1], slot_q[0]} + {slot_q[2][DW-1], slot_q[2]};
        sum_q = {slot_q[1][DW-1], slot_q[1]} + {slot_q[3][DW-1], slot_q[3]};
        avg_i = sum_i[DW:1];
        avg_q = sum_q[DW:1];
    end

    // Register the outputs and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_valid <= 1'b0;
            i_out    <= '0;
            q_out    <= '0;
        end else begin
            iq_valid <= done_q;
            if (done_q) begin
                i_out <= {{EXT{avg_i[DW-1]}}, avg_i};
                q_out <= {{EXT{avg_q[DW-1]}}, avg_q};
            end
        end
    end

endmodule

// File: rtl/iq_undersample_det.sv
// Undersampled IQ detector top.
// Tracks the group position, corrects signs per regime and averages each
// group of four samples into one registered I/Q pair with a strobe.
// Assumes one sample per clock at most, flagged by smp_valid.
module iq_undersample_det
    import iqd_pkg::*;
#(
    parameter int unsigned DW = 14,
    parameter int unsigned OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    input  logic                 sync,
    input  logic                 regime_sel,
    output logic                 iq_valid,
    output logic signed [OW-1:0] i_out,
    output logic signed [OW-1:0] q_out
);

    logic [PH_W-1:0]      ph_cur;
    logic [PH_W-1:0]      phase_q;
    regime_e              regime_q;
    logic                 grp_last;
    logic signed [DW-1:0] smp_fix;

    iqd_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .sync       (sync),
        .regime_sel (regime_sel),
        .ph_cur     (ph_cur),
        .phase_q    (phase_q),
        .regime_q   (regime_q),
        .grp_last   (grp_last)
    );

    iqd_sign_fix #(.DW(DW)) u_fix (
        .smp_in  (smp_data),
        .ph_cur  (ph_cur),
        .regime  (regime_q),
        .smp_fix (smp_fix)
    );

    iqd_combine #(.DW(DW), .OW(OW)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .ph_cur    (ph_cur),
        .smp_fix   (smp_fix),
        .grp_last  (grp_last),
        .iq_valid  (iq_valid),
        .i_out     (i_out),
        .q_out     (q_out)
    );

endmodule

// File: rtl/iqd_checker.sv
// Protocol checker for the undersampled IQ detector, bound to the top.
// Observes ports plus the stored group position and captured regime.
module iqd_checker #(
    parameter int unsigned DW = 14,
    parameter int unsigned OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          sync,
    input logic          iq_valid,
    input logic [OW-1:0] i_out,
    input logic [OW-1:0] q_out,
    input logic [1:0]    phase,
    input logic          regime
);

    // R5: the strobe never lasts two cycles.
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |=> !iq_valid);

    // R5: a strobe follows a non-sync fourth sample two edges earlier.
    p_strobe_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> $past(smp_valid && !sync && phase == 2'd3, 2));

    // R5: outputs hold between strobes.
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !iq_valid |-> ($stable(i_out) && $stable(q_out)));

    // R6: idle cycles leave the group position alone.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(phase));

    // R7: a sync sample is taken as the first of a group.
    p_sync_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && sync) |=> (phase == 2'd1));

    // R8: the regime only moves at a group's first sample.
    p_regime_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && (sync || phase == 2'd0)) |=> $stable(regime));

    // R9: outputs are sign extensions of a DW-bit value.
    p_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> (i_out[OW-1:DW-1] == {(OW-DW+1){i_out[OW-1]}} &&
                      q_out[OW-1:DW-1] == {(OW-DW+1){q_out[OW-1]}}));

endmodule

bind iq_undersample_det iqd_checker #(.DW(DW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .sync      (sync),
    .iq_valid  (iq_valid),
    .i_out     (i_out),
    .q_out     (q_out),
    .phase     (phase_q),
    .regime    (regime_q)
);

// File: tb/tb_iq_undersample_det.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each group result, the monitor pops
// and compares at every strobe.
module tb_iq_undersample_det;

    localparam int DW   = 14;
    localparam int OW   = 16;
    localparam int MINV = -(1 << (DW - 1));
    localparam int MAXV = (1 << (DW - 1)) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic                 sync = 1'b0;
    logic                 regime_sel = 1'b0;
    logic                 iq_valid;
    logic signed [OW-1:0] i_out;
    logic signed [OW-1:0] q_out;

    iq_undersample_det #(.DW(DW), .OW(OW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .sync(sync), .regime_sel(regime_sel), .iq_valid(iq_valid),
        .i_out(i_out), .q_out(q_out)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    int    exp_i[$];
    int    exp_q[$];
    int    exp_cyc[$];
    string exp_tag[$];

    int m_ph = 0;
    bit m_reg = 1'b0;
    int m_slot[4];

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int neg_sat(int x);
        return (x == MINV) ? MAXV : -x;
    endfunction

    // Driver: present one sample, predict the group result per R2/R3/R4/R7/R8.
    task automatic put(int d, bit sy, string tag);
        int ph;
        int c;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = d[DW-1:0];
        sync      = sy;
        ph = sy ? 0 : m_ph;
        if (ph == 0) m_reg = regime_sel;
        c = d;
        if (ph == 2 || (ph == 1 && m_reg) || (ph == 3 && !m_reg)) c = neg_sat(d);
        m_slot[ph] = c;
        @(posedge clk);
        #1;
        if (ph == 3) begin
            exp_i.push_back((m_slot[0] + m_slot[2]) >>> 1);
            exp_q.push_back((m_slot[1] + m_slot[3]) >>> 1);
            exp_cyc.push_back(cyc + 1);
            exp_tag.push_back(tag);
        end
        m_ph = (ph + 1) % 4;
        smp_valid = 1'b0;
        sync = 1'b0;
    endtask

    task automatic group4(int a, int b, int c, int d, string tag);
        put(a, 1'b0, tag);
        put(b, 1'b0, tag);
        put(c, 1'b0, tag);
        put(d, 1'b0, tag);
    endtask

    function automatic int rnd();
        return int'($urandom_range(2 * MAXV + 1)) + MINV;
    endfunction

    // Monitor: compare every strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && iq_valid && !finished) begin
            if (exp_i.size() == 0) begin
                chk(1'b0, "R7", "strobe with no group expected", 1, 0);
            end else begin
                int ei, eq, ec;
                string t;
                ei = exp_i.pop_front();
                eq = exp_q.pop_front();
                ec = exp_cyc.pop_front();
                t  = exp_tag.pop_front();
                chk(int'(i_out) == ei, t, "i_out", int'(i_out), ei);
                chk(int'(q_out) == eq, t, "q_out", int'(q_out), eq);
                chk(cyc == ec, "R5", "strobe cycle", cyc, ec);
                // R9: upper bits replicate the sign of the 14-bit average
                chk(i_out[OW-1:DW-1] == {(OW-DW+1){i_out[OW-1]}}, "R9",
                    "i_out sign extension", int'(i_out), ei);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(iq_valid == 1'b0, "R1", "iq_valid in reset", int'(iq_valid), 0);
        chk(i_out == '0, "R1", "i_out in reset", int'(i_out), 0);
        chk(q_out == '0, "R1", "q_out in reset", int'(q_out), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(iq_valid == 1'b0, "R1", "iq_valid idle after reset", int'(iq_valid), 0);

        // R2: forward regime, fixed and random groups back to back
        regime_sel = 1'b0;
        group4(100, 50, -60, -20, "R2");
        group4(-7, 3, 8, -3, "R2");
        for (int g = 0; g < 8; g++) group4(rnd(), rnd(), rnd(), rnd(), "R2");

        // R6: idle gaps between samples of a group
        put(1000, 1'b0, "R6");
        repeat (3) @(negedge clk);
        put(-400, 1'b0, "R6");
        repeat (5) @(negedge clk);
        put(-900, 1'b0, "R6");
        @(negedge clk);
        put(401, 1'b0, "R6");
        repeat (4) @(negedge clk);

        // R3: reverse regime
        regime_sel = 1'b1;
        group4(100, 50, -60, -20, "R3");
        for (int g = 0; g < 8; g++) group4(rnd(), rnd(), rnd(), rnd(), "R3");

        // R4: saturating negation in both regimes
        group4(MAXV, MINV, MINV, 5, "R4");
        regime_sel = 1'b0;
        group4(MAXV, MINV, MINV, MINV, "R4");
        group4(MINV, 0, MAXV, MINV, "R4");

        // R7: sync after two samples, then sync in place of a fourth sample
        put(1111, 1'b0, "R7");
        put(2222, 1'b0, "R7");
        put(300, 1'b1, "R7");
        put(-100, 1'b0, "R7");
        put(-50, 1'b0, "R7");
        put(70, 1'b0, "R7");
        put(5, 1'b0, "R7");
        put(6, 1'b0, "R7");
        put(7, 1'b0, "R7");
        put(-2000, 1'b1, "R7");
        put(1234, 1'b0, "R7");
        put(600, 1'b0, "R7");
        put(-321, 1'b0, "R7");
        repeat (3) @(negedge clk);

        // R8: regime change mid group applies from the next group
        regime_sel = 1'b0;
        put(800, 1'b0, "R8");
        put(300, 1'b0, "R8");
        regime_sel = 1'b1;
        put(-200, 1'b0, "R8");
        put(-100, 1'b0, "R8");
        group4(800, 300, -200, -100, "R8");
        regime_sel = 1'b0;
        put(10, 1'b0, "R8");
        regime_sel = 1'b1;
        put(20, 1'b0, "R8");
        put(30, 1'b0, "R8");
        put(40, 1'b0, "R8");

        repeat (6) @(negedge clk);
        // R7/R5: every predicted group produced exactly one strobe
        chk(exp_i.size() == 0, "R7", "unmatched expected groups", exp_i.size(), 0);
        chk(iq_valid == 1'b0, "R5", "no strobe when idle", int'(iq_valid), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule